// File: doc/BRIEF.md
# Store Queue with Deferred Writeback

This block keeps the stores of an out-of-order core in a circular buffer from dispatch until their data has reached the data cache. Stores take slots in program order at the tail. Execution later fills in each entry's address, data and access size. A retire signal carrying the youngest retired sequence number marks entries as ready to write. A separate writeback pointer then sends ready entries to the cache, oldest first, up to a fixed number of write lanes per cycle.

The cache returns completions by entry index, in any order. An entry that completes away from the head only records that it is done. When the head entry is done, the head advances over the whole run of done entries in one step. A pipeline flush removes young, not yet retired entries from the tail side and stops at the first entry that is already ready to write.

The buffer has one slot more than its usable capacity, so a full queue and an empty queue never share a pointer pattern. Occupancy and free-slot counts are outputs. Address translation and forwarding from stores to loads are handled by other blocks.

Top module: `sq_store_queue`

## Requirements
- R1: After reset the queue is empty: occupancy 0, free_slots equal to DEPTH, empty high, full low, and no write lane valid.
- R2: An accepted allocation takes the slot shown on alloc_idx (the tail) and raises occupancy by one on the next cycle. Slot indices run from 0 to DEPTH and then wrap to 0.
- R3: With DEPTH entries held, full is high. An allocation request made while full raises err_overflow in that cycle, and it is dropped: the tail and the occupancy do not change.
- R4: A retire request marks entries ready, walking from the head. It skips entries that are already ready and stops at the first unready entry whose sequence number (unsigned) is greater than commit_seq. Ready entries are offered to the cache in the cycle after the mark, in queue order, and the offer stops at the first entry that is not ready.
- R5: At most PORTS write lanes are valid in a cycle. Lane 0 carries the oldest entry, and each lane gives the entry index, address, size and data.
- R6: An entry whose stored size is 0 reaches the writeback pointer and is completed there without a write request and without using a lane. Lanes that follow it still carry later entries in the same cycle.
- R7: While cache_blocked is high, no write lane is valid. Writes resume in the first cycle in which cache_blocked is low.
- R8: The legal sizes are 0, 1, 2, 4 and 8 bytes. An execute with any other size raises err_size in that cycle, and the entry is then handled as a size-0 entry.
- R9: A completion marks its entry done. Occupancy does not drop while the head entry is not done. One cycle after the head entry is done, the head passes every consecutive done entry, and occupancy falls by the length of that run.
- R10: A squash removes entries from the tail backwards while their sequence number is greater than squash_seq. It stops at the first entry that is ready to write. The next allocation reuses the lowest freed slot.
- R11: An execute flagged as a conditional store with a legal nonzero size marks the entry ready by itself, so the entry is written without waiting for a retire request.
- R12: free_slots always equals DEPTH minus occupancy, and full is high exactly when free_slots is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| exec_valid | input | 1 | Execute result for an entry |
| exec_idx | input | IDX_W | Entry being executed |
| exec_addr | input | ADDR_W | Store address |
| exec_size | input | 4 | Access size in bytes |
| exec_data | input | DATA_W | Store data |
| exec_cond | input | 1 | Entry is a conditional store |
| commit_valid | input | 1 | Retire request |
| commit_seq | input | SEQ_W | Youngest retired sequence number |
| wr_valid | output | PORTS | Write request per lane |
| wr_idx | output | PORTS*IDX_W | Entry index per lane |
| wr_addr | output | PORTS*ADDR_W | Address per lane |
| wr_size | output | PORTS*4 | Size per lane |
| wr_data | output | PORTS*DATA_W | Data per lane |
| cache_blocked | input | 1 | Cache cannot take writes this cycle |
| cmp_valid | input | 1 | Write completion |
| cmp_idx | input | IDX_W | Entry index of the completion |
| squash_valid | input | 1 | Flush younger stores |
| squash_seq | input | SEQ_W | Entries newer than this are removed |
| occupancy | output | CNT_W | Entries held |
| free_slots | output | CNT_W | Usable slots left |
| full | output | 1 | No usable slot left |
| empty | output | 1 | No entry held |
| err_overflow | output | 1 | Allocation requested while full |
| err_size | output | 1 | Execute with an illegal size |

## Verification
Two things can retire work in the same cycle: a completion returned by the cache, and the writeback walk skipping a size-0 entry. Both lower the count of ready-but-unfinished entries. The bench sets this up by letting a normal store issue, retiring a size-0 store behind it, and returning the first store's completion on the edge where the walk skips the size-0 entry. The result is accepted if both entries leave the queue on the same later edge and a store retired after that is still offered to the cache, which a miscounted pending total would block.

// File: rtl/sq_pkg.sv
package sq_pkg;

  localparam int SIZE_W = 4;

  // Legal nonzero access sizes in bytes.
  function automatic logic size_is_legal(input logic [SIZE_W-1:0] sz);
    return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
  endfunction

  // Circular index arithmetic over a ring of 'slots' entries.
  function automatic int ring_next(input int idx, input int slots);
    return (idx + 1 >= slots) ? 0 : idx + 1;
  endfunction

  function automatic int ring_prev(input int idx, input int slots);
    return (idx == 0) ? slots - 1 : idx - 1;
  endfunction

  function automatic int ring_span(input int from_idx, input int to_idx, input int slots);
    return (to_idx >= from_idx) ? to_idx - from_idx : to_idx + slots - from_idx;
  endfunction

  function automatic int ones(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [IDX_W-1:0]       head,
  input  logic [IDX_W-1:0]       tail,
  input  logic [SLOTS-1:0]       ready,
  input  logic [SLOTS*SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0]       youngest,
  output logic [SLOTS-1:0]       mark
);

  // Walk from the head; already-ready entries are passed over, the first
  // unready entry younger than the retire point ends the walk.
  always_comb begin
    int  i;
    logic stop;
    i    = int'(head);
    stop = 1'b0;
    mark = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (i == int'(tail)) begin
          stop = 1'b1;
        end else begin
          if (!ready[i]) begin
            if (seq[i*SEQ_W +: SEQ_W] > youngest) stop = 1'b1;
            else mark[i] = 1'b1;
          end
          if (!stop) i = ring_next(i, SLOTS);
        end
      end
    end
  end

endmodule

// File: rtl/sq_wb_scan.sv
module sq_wb_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int PORTS = 2,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [IDX_W-1:0]       wb_ptr,
  input  logic [IDX_W-1:0]       tail,
  input  logic [SLOTS-1:0]       ready,
  input  logic [SLOTS-1:0]       executed,
  input  logic [SLOTS-1:0]       zero_size,
  input  logic                   blocked,
  input  logic                   pending_nz,
  output logic [SLOTS-1:0]       skip_mask,
  output logic [SLOTS-1:0]       issue_mask,
  output logic [PORTS-1:0]       lane_vld,
  output logic [PORTS*IDX_W-1:0] lane_idx,
  output logic [IDX_W-1:0]       wb_next
);

  // Zero-size entries retire in place and cost no lane; a blocked cache or
  // an exhausted lane budget ends the walk at the first real write.
  always_comb begin
    int  p;
    int  used;
    logic stop;
    p          = int'(wb_ptr);
    used       = 0;
    stop       = 1'b0;
    skip_mask  = '0;
    issue_mask = '0;
    lane_vld   = '0;
    lane_idx   = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (!pending_nz || p == int'(tail) || !ready[p] || !executed[p]) begin
          stop = 1'b1;
        end else if (zero_size[p]) begin
          skip_mask[p] = 1'b1;
          p = ring_next(p, SLOTS);
        end else if (blocked || used >= PORTS) begin
          stop = 1'b1;
        end else begin
          issue_mask[p] = 1'b1;
          lane_vld[used] = 1'b1;
          lane_idx[used*IDX_W +: IDX_W] = IDX_W'(p);
          used = used + 1;
          p = ring_next(p, SLOTS);
        end
      end
    end
    wb_next = IDX_W'(p);
  end

endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [IDX_W-1:0]       head,
  input  logic [IDX_W-1:0]       tail,
  input  logic [SLOTS-1:0]       ready,
  input  logic [SLOTS*SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0]       squash_seq,
  output logic [SLOTS-1:0]       kill_mask,
  output logic [IDX_W-1:0]       tail_next
);

  // Backward walk from the tail; ready entries are retired work and end it.
  always_comb begin
    int  t;
    int  prv;
    logic stop;
    t         = int'(tail);
    stop      = 1'b0;
    kill_mask = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        prv = ring_prev(t, SLOTS);
        if (t == int'(head) || ready[prv] || (seq[prv*SEQ_W +: SEQ_W] <= squash_seq)) begin
          stop = 1'b1;
        end else begin
          kill_mask[prv] = 1'b1;
          t = prv;
        end
      end
    end
    tail_next = IDX_W'(t);
  end

endmodule

// File: rtl/sq_retire_scan.sv
module sq_retire_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  input  logic [SLOTS-1:0] done,
  output logic [SLOTS-1:0] retire_mask,
  output logic [IDX_W-1:0] head_next
);

  // The head passes the whole run of consecutive done entries at once.
  always_comb begin
    int  h;
    logic stop;
    h           = int'(head);
    stop        = 1'b0;
    retire_mask = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!stop) begin
        if (h == int'(tail) || !done[h]) begin
          stop = 1'b1;
        end else begin
          retire_mask[h] = 1'b1;
          h = ring_next(h, SLOTS);
        end
      end
    end
    head_next = IDX_W'(h);
  end

endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int PORTS  = 2,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SLOTS = DEPTH + 1,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic [SEQ_W-1:0]        alloc_seq,
  output logic [IDX_W-1:0]        alloc_idx,
  input  logic                    exec_valid,
  input  logic [IDX_W-1:0]        exec_idx,
  input  logic [ADDR_W-1:0]       exec_addr,
  input  logic [SIZE_W-1:0]       exec_size,
  input  logic [DATA_W-1:0]       exec_data,
  input  logic                    exec_cond,
  input  logic                    commit_valid,
  input  logic [SEQ_W-1:0]        commit_seq,
  output logic [PORTS-1:0]        wr_valid,
  output logic [PORTS*IDX_W-1:0]  wr_idx,
  output logic [PORTS*ADDR_W-1:0] wr_addr,
  output logic [PORTS*SIZE_W-1:0] wr_size,
  output logic [PORTS*DATA_W-1:0] wr_data,
  input  logic                    cache_blocked,
  input  logic                    cmp_valid,
  input  logic [IDX_W-1:0]        cmp_idx,
  input  logic                    squash_valid,
  input  logic [SEQ_W-1:0]        squash_seq,
  output logic [CNT_W-1:0]        occupancy,
  output logic [CNT_W-1:0]        free_slots,
  output logic                    full,
  output logic                    empty,
  output logic                    err_overflow,
  output logic                    err_size
);

  // Pointers and per-entry state
  logic [IDX_W-1:0]       head_q, tail_q, wb_q;
  logic [SLOTS*SEQ_W-1:0] seq_q;
  logic [ADDR_W-1:0]      addr_q [SLOTS];
  logic [DATA_W-1:0]      data_q [SLOTS];
  logic [SIZE_W-1:0]      size_q [SLOTS];
  logic [SLOTS-1:0]       exec_q, ready_q, issued_q, done_q;
  logic [CNT_W-1:0]       pend_q;

  // Named internal events
  logic                   alloc_fire, exec_legal;
  logic [SLOTS-1:0]       zero_mask, commit_raw, commit_mark, sc_mask, cmp_mask;
  logic [SLOTS-1:0]       skip_mask, issue_mask, kill_mask, kill_eff, retire_mask;
  logic [SLOTS-1:0]       set_mask, alloc_mask, exec_mask, keep_mask;
  logic [SLOTS-1:0]       exec_d, ready_d, issued_d, done_d;
  logic [PORTS*IDX_W-1:0] lane_idx;
  logic [IDX_W-1:0]       wb_next, tail_sq, head_next;
  logic [CNT_W-1:0]       pend_d;

  // Occupancy view
  assign empty        = (head_q == tail_q);
  assign full         = (int'(head_q) == ring_next(int'(tail_q), SLOTS));
  assign occupancy    = CNT_W'(ring_span(int'(head_q), int'(tail_q), SLOTS));
  assign free_slots   = CNT_W'(DEPTH) - occupancy;
  assign alloc_idx    = tail_q;

  // Request qualification
  assign alloc_fire   = alloc_valid && !full && !squash_valid;
  assign err_overflow = alloc_valid && full;
  assign exec_legal   = size_is_legal(exec_size);
  assign err_size     = exec_valid && !exec_legal && (exec_size != '0);

  for (genvar s = 0; s < SLOTS; s++) begin : g_zero
    assign zero_mask[s] = (size_q[s] == '0);
  end

  sq_commit_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) i_commit (
    .head(head_q), .tail(tail_q), .ready(ready_q), .seq(seq_q),
    .youngest(commit_seq), .mark(commit_raw)
  );

  sq_wb_scan #(.SLOTS(SLOTS), .PORTS(PORTS)) i_wb (
    .wb_ptr(wb_q), .tail(tail_q), .ready(ready_q), .executed(exec_q),
    .zero_size(zero_mask), .blocked(cache_blocked), .pending_nz(pend_q != '0),
    .skip_mask(skip_mask), .issue_mask(issue_mask), .lane_vld(wr_valid),
    .lane_idx(lane_idx), .wb_next(wb_next)
  );

  sq_squash_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) i_squash (
    .head(head_q), .tail(tail_q), .ready(ready_q), .seq(seq_q),
    .squash_seq(squash_seq), .kill_mask(kill_mask), .tail_next(tail_sq)
  );

  sq_retire_scan #(.SLOTS(SLOTS)) i_retire (
    .head(head_q), .tail(tail_q), .done(done_q),
    .retire_mask(retire_mask), .head_next(head_next)
  );

  // Write lanes: per-lane mux from the entry storage
  assign wr_idx = lane_idx;
  for (genvar l = 0; l < PORTS; l++) begin : g_lane
    logic [IDX_W-1:0] sel;
    assign sel = lane_idx[l*IDX_W +: IDX_W];
    assign wr_addr[l*ADDR_W +: ADDR_W] = wr_valid[l] ? addr_q[sel] : '0;
    assign wr_data[l*DATA_W +: DATA_W] = wr_valid[l] ? data_q[sel] : '0;
    assign wr_size[l*SIZE_W +: SIZE_W] = wr_valid[l] ? size_q[sel] : '0;
  end

  // Next-state masks
  always_comb begin
    commit_mark = commit_valid ? commit_raw : '0;
    sc_mask     = (exec_valid && exec_cond && exec_legal) ? (SLOTS'(1) << exec_idx) : '0;
    cmp_mask    = cmp_valid ? (SLOTS'(1) << cmp_idx) : '0;
    kill_eff    = squash_valid ? kill_mask : '0;
    set_mask    = (commit_mark | sc_mask) & ~ready_q & ~kill_eff;
    alloc_mask  = alloc_fire ? (SLOTS'(1) << tail_q) : '0;
    exec_mask   = exec_valid ? (SLOTS'(1) << exec_idx) : '0;
    keep_mask   = ~(retire_mask | alloc_mask);
    exec_d      = (exec_q | exec_mask) & keep_mask;
    ready_d     = (ready_q | set_mask) & keep_mask;
    issued_d    = (issued_q | issue_mask) & keep_mask;
    done_d      = (done_q | skip_mask | cmp_mask) & keep_mask;
    pend_d      = pend_q + CNT_W'(ones(64'(set_mask)))
                         - CNT_W'(ones(64'(skip_mask)))
                         - CNT_W'(cmp_valid);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      wb_q     <= '0;
      seq_q    <= '0;
      exec_q   <= '0;
      ready_q  <= '0;
      issued_q <= '0;
      done_q   <= '0;
      pend_q   <= '0;
    end else begin
      head_q   <= head_next;
      wb_q     <= wb_next;
      pend_q   <= pend_d;
      exec_q   <= exec_d;
      ready_q  <= ready_d;
      issued_q <= issued_d;
      done_q   <= done_d;
      if (squash_valid) tail_q <= tail_sq;
      else if (alloc_fire) tail_q <= IDX_W'(ring_next(int'(tail_q), SLOTS));
      if (alloc_fire) seq_q[int'(tail_q)*SEQ_W +: SEQ_W] <= alloc_seq;
    end
  end

  // Entry payload, written by execute; an illegal size is kept as zero.
  always_ff @(posedge clk) begin
    if (exec_valid) begin
      addr_q[exec_idx] <= exec_addr;
      data_q[exec_idx] <= exec_data;
      size_q[exec_idx] <= exec_legal ? exec_size : '0;
    end
  end

  // Assertions
  assert_overflow_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && full && !squash_valid) |=> (tail_q == $past(tail_q)));

  assert_pending_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= occupancy);

  assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked |-> (wr_valid == '0));

  assert_completion_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> (issued_q[cmp_idx] && !done_q[cmp_idx]));

  assert_retire_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_mask & ~done_q) == '0);

  assert_squash_spares_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> ((kill_mask & ready_q) == '0));

  assert_cond_store_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_cond && size_is_legal(exec_size) && !squash_valid)
      |=> ready_q[$past(exec_idx)]);

endmodule

// File: tb/test_sq_store_queue.sv
`timescale 1ns/1ps
module test_sq_store_queue;

  localparam int DEPTH = 4, PORTS = 2, SEQ_W = 16, ADDR_W = 32, DATA_W = 32;
  localparam int SLOTS = DEPTH + 1, IDX_W = 3, CNT_W = 3;

  // Vector table: {size[3:0], expect err_size, expect a write request}
  localparam int NVEC = 9;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0000_0_0, 6'b0001_0_1, 6'b0010_0_1, 6'b0011_1_0, 6'b0100_0_1,
    6'b0101_1_0, 6'b1000_0_1, 6'b1001_1_0, 6'b1111_1_0 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid, exec_valid, exec_cond, commit_valid, cache_blocked;
  logic cmp_valid, squash_valid;
  logic [SEQ_W-1:0] alloc_seq, commit_seq, squash_seq;
  logic [IDX_W-1:0] exec_idx, cmp_idx, alloc_idx;
  logic [ADDR_W-1:0] exec_addr;
  logic [3:0] exec_size;
  logic [DATA_W-1:0] exec_data;
  logic [PORTS-1:0] wr_valid;
  logic [PORTS*IDX_W-1:0] wr_idx;
  logic [PORTS*ADDR_W-1:0] wr_addr;
  logic [PORTS*4-1:0] wr_size;
  logic [PORTS*DATA_W-1:0] wr_data;
  logic [CNT_W-1:0] occupancy, free_slots;
  logic full, empty, err_overflow, err_size;

  int n_chk = 0;
  int n_err = 0;
  int exp_tail = 0;

  always #2 clk = ~clk;

  sq_store_queue #(.DEPTH(DEPTH), .PORTS(PORTS), .SEQ_W(SEQ_W),
                   .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sq_store_queue (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_size(exec_size), .exec_data(exec_data), .exec_cond(exec_cond),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .cache_blocked(cache_blocked),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .occupancy(occupancy), .free_slots(free_slots), .full(full), .empty(empty),
    .err_overflow(err_overflow), .err_size(err_size)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0; exec_valid = 1'b0; exec_cond = 1'b0;
    commit_valid = 1'b0; cmp_valid = 1'b0; squash_valid = 1'b0;
  endtask

  // Inputs change 1 ns after a rising edge; outputs are read before the next.
  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic alloc(input int seq, input int exp_idx, input string req);
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(seq);
    #0.5;
    check(req, "alloc_idx", 64'(alloc_idx), 64'(exp_idx));
    tick();
    exp_tail = (exp_tail + 1) % SLOTS;
  endtask

  task automatic exec(input int idx, input int addr, input int size,
                      input int data, input logic cond);
    exec_valid = 1'b1; exec_idx = IDX_W'(idx); exec_addr = ADDR_W'(addr);
    exec_size = 4'(size); exec_data = DATA_W'(data); exec_cond = cond;
    tick();
  endtask

  task automatic commit(input int seq);
    commit_valid = 1'b1; commit_seq = SEQ_W'(seq);
    tick();
  endtask

  task automatic complete(input int idx);
    cmp_valid = 1'b1; cmp_idx = IDX_W'(idx);
    tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    idle();
    cache_blocked = 1'b0;
    alloc_seq = '0; commit_seq = '0; squash_seq = '0;
    exec_idx = '0; exec_addr = '0; exec_size = '0; exec_data = '0; cmp_idx = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    check("R1", "empty", 64'(empty), 64'd1);
    check("R1", "full", 64'(full), 64'd0);
    check("R1", "occupancy", 64'(occupancy), 64'd0);
    check("R1", "free_slots", 64'(free_slots), 64'd4);
    check("R1", "wr_valid", 64'(wr_valid), 64'd0);

    // R2, R3, R12: fill, then overflow
    for (int i = 0; i < 4; i++) alloc(10 + i, i, "R2");
    check("R3", "full", 64'(full), 64'd1);
    check("R12", "free_slots", 64'(free_slots), 64'd0);
    check("R2", "occupancy", 64'(occupancy), 64'd4);
    alloc_valid = 1'b1; alloc_seq = 16'd99;
    #0.5;
    check("R3", "err_overflow", 64'(err_overflow), 64'd1);
    tick();
    check("R3", "occupancy after drop", 64'(occupancy), 64'd4);
    check("R3", "tail after drop", 64'(alloc_idx), 64'd4);

    // R4, R5: retire two of four, two lanes in order
    for (int i = 0; i < 4; i++) exec(i, 32'h100 + i * 8, 4, 32'hA0 + i, 1'b0);
    commit(11);
    check("R5", "wr_valid", 64'(wr_valid), 64'd3);
    check("R5", "lane0 idx", 64'(wr_idx[2:0]), 64'd0);
    check("R5", "lane1 idx", 64'(wr_idx[5:3]), 64'd1);
    check("R5", "lane0 addr", 64'(wr_addr[31:0]), 64'h100);
    check("R5", "lane1 data", 64'(wr_data[63:32]), 64'hA1);
    tick();
    check("R4", "walk stops at unretired", 64'(wr_valid), 64'd0);

    // R9: out-of-order completion
    complete(1);
    tick();
    check("R9", "non-head done keeps occupancy", 64'(occupancy), 64'd4);
    complete(0);
    check("R9", "head moves one cycle later", 64'(occupancy), 64'd4);
    tick();
    check("R9", "run of two retired", 64'(occupancy), 64'd2);

    // R2 wrap, R7 blocked, R10 squash
    alloc(14, 4, "R2");
    alloc(15, 0, "R2");
    exec(4, 32'h400, 2, 32'hB4, 1'b0);
    exec(0, 32'h410, 2, 32'hB0, 1'b0);
    cache_blocked = 1'b1;
    commit(12);
    check("R7", "blocked no request", 64'(wr_valid), 64'd0);
    squash_valid = 1'b1; squash_seq = 16'd12;
    tick();
    exp_tail = 3;
    check("R10", "occupancy after squash", 64'(occupancy), 64'd1);
    alloc(16, 3, "R10");
    exec(3, 32'h300, 8, 32'hC3, 1'b0);
    cache_blocked = 1'b0;
    #0.5;
    check("R7", "resume wr_valid", 64'(wr_valid), 64'd1);
    check("R7", "resume lane0 idx", 64'(wr_idx[2:0]), 64'd2);
    check("R7", "resume lane0 size", 64'(wr_size[3:0]), 64'd4);
    tick();
    complete(2);
    tick();
    check("R9", "occupancy", 64'(occupancy), 64'd1);

    // R11: conditional store issues without retire
    commit(16);
    check("R4", "lane0 idx", 64'(wr_idx[2:0]), 64'd3);
    check("R4", "lane0 data", 64'(wr_data[31:0]), 64'hC3);
    tick();
    complete(3);
    tick();
    check("R9", "empty", 64'(empty), 64'd1);
    alloc(20, 4, "R2");
    exec(4, 32'h700, 8, 32'hD4, 1'b1);
    check("R11", "wr_valid", 64'(wr_valid), 64'd1);
    check("R11", "lane0 idx", 64'(wr_idx[2:0]), 64'd4);
    tick();
    complete(4);
    tick();
    check("R11", "empty", 64'(empty), 64'd1);

    // R6, R8: size table
    for (int v = 0; v < NVEC; v++) begin
      int idx;
      idx = exp_tail;
      alloc(30 + v, idx, "R2");
      exec_valid = 1'b1; exec_idx = IDX_W'(idx); exec_addr = 32'h800 + v;
      exec_size = VEC[v][5:2]; exec_data = 32'hE0 + v; exec_cond = 1'b0;
      #0.5;
      check("R8", "err_size", 64'(err_size), 64'(VEC[v][1]));
      tick();
      commit(30 + v);
      check("R6", "write request", 64'(wr_valid), 64'(VEC[v][0]));
      if (VEC[v][0]) check("R8", "lane0 size", 64'(wr_size[3:0]), 64'(VEC[v][5:2]));
      tick();
      if (VEC[v][0]) complete(idx);
      tick();
      check("R6", "entry retired", 64'(empty), 64'd1);
    end

    // R5, R6: a size-0 entry between two writes uses no lane
    alloc(50, exp_tail, "R2");
    alloc(51, exp_tail, "R2");
    alloc(52, exp_tail, "R2");
    check("R12", "free_slots", 64'(free_slots), 64'd1);
    exec(4, 32'h500, 4, 32'hF0, 1'b0);
    exec(0, 32'h510, 0, 32'hF1, 1'b0);
    exec(1, 32'h520, 4, 32'hF2, 1'b0);
    commit(52);
    check("R6", "two lanes", 64'(wr_valid), 64'd3);
    check("R6", "lane0 idx", 64'(wr_idx[2:0]), 64'd4);
    check("R6", "lane1 idx", 64'(wr_idx[5:3]), 64'd1);
    tick();
    complete(1);
    tick();
    check("R9", "head not done", 64'(occupancy), 64'd3);
    complete(4);
    tick();
    check("R9", "run of three retired", 64'(empty), 64'd1);

    // Same-edge completion and zero-size skip
    alloc(60, 2, "R2");
    alloc(61, 3, "R2");
    exec(2, 32'h600, 4, 32'h60, 1'b0);
    exec(3, 32'h610, 0, 32'h61, 1'b0);
    commit(60);
    check("R4", "single lane", 64'(wr_valid), 64'd1);
    tick();
    commit(61);
    check("R6", "zero-size no request", 64'(wr_valid), 64'd0);
    complete(2);
    tick();
    check("R9", "both retired together", 64'(empty), 64'd1);
    alloc(62, 4, "R2");
    exec(4, 32'h620, 4, 32'h62, 1'b0);
    commit(62);
    check("R4", "later store still issues", 64'(wr_valid), 64'd1);
    check("R4", "later store idx", 64'(wr_idx[2:0]), 64'd4);
    tick();
    complete(4);
    tick();
    check("R12", "free_slots at end", 64'(free_slots), 64'd4);

    summary();
  end

endmodule